// File: doc/BRIEF.md
# Segment Base-and-Bounds Address Translator

This block turns a logical access into a physical one under a segmented memory scheme. A small register table holds one descriptor per segment, and each descriptor has three fields: a base address, a lower bound and an upper bound. A request names a segment and gives a logical offset. The block adds the offset to that segment's base and checks the offset against the segment's bounds. The result comes back one registered cycle later, either as a translated physical address or as a range-error response.

Software fills the table one field at a time through a write port. Any segment can be placed anywhere in physical memory. A segment can also be moved while the system runs: rewriting only its base field moves it, and its logical addresses and bounds stay as they were. Requests and responses each use a valid/ready handshake. The single response slot holds its contents while the consumer stalls.

Top module: `seg_xlat`

## Requirements
- R1: After reset, rsp_valid and rsp_err are low and req_ready is high. Every descriptor field resets to zero, so any request made before configuration gets a range-error response.
- R2: A request accepted at a clock edge (req_valid and req_ready both high) produces its response just after that edge. For an in-range request, rsp_valid is high and rsp_paddr equals base + req_off modulo 2^32. A carry out of bit 31 is dropped.
- R3: A request is in range when lower <= req_off < upper, using unsigned comparison. An offset equal to the lower bound passes. An offset equal to the upper bound fails, and so does an offset below the lower bound.
- R4: An out-of-range request produces a response with rsp_err high, rsp_valid low and rsp_paddr equal to zero. rsp_valid and rsp_err are never high together.
- R5: A descriptor write at clock edge N applies only to requests accepted at edge N+1 or later. A request accepted at the same edge as the write is translated with the old descriptor.
- R6: While a response is held (rsp_valid or rsp_err high) and rsp_ready is low, the response stays unchanged and req_ready is low. When rsp_ready is high, a new request can be accepted at the same edge that the held response is consumed.
- R7: cfg_field selects the field to write: 0 is base, 1 is lower bound, 2 is upper bound. A write with code 3 changes nothing. Rewriting only the base relocates a segment, and its bounds remain in force.
- R8: Each value of req_seg selects its own descriptor. A write to one segment does not change the translation of any other segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_seg | input | 3 | Segment whose descriptor is written |
| cfg_field | input | 2 | Field select: 0 base, 1 lower, 2 upper, 3 none |
| cfg_data | input | 32 | Value written into the selected field |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_seg | input | 3 | Segment number of the request |
| req_off | input | 32 | Logical offset within the segment |
| rsp_valid | output | 1 | Translated address is present |
| rsp_err | output | 1 | Range-error response is present |
| rsp_ready | input | 1 | Consumer takes the response this cycle |
| rsp_paddr | output | 32 | Physical address, zero on a range error |

## Verification
The assertions check on every cycle that:
- a range-error response carries a zero address and never appears with rsp_valid;
- every accepted request fills the response slot at the next edge;
- a stalled response stays unchanged while the request side is held off.

Only the bench's scenarios can show the rest:
- the arithmetic of the translation, including the dropped carry;
- the exact placement of the inclusive and exclusive bound edges;
- the one-cycle visibility rule for descriptor writes;
- that relocation by a base-only write keeps the old bounds.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
   typedef enum logic [1:0] {
      FLD_BASE  = 2'd0,
      FLD_LOWER = 2'd1,
      FLD_UPPER = 2'd2,
      FLD_NONE  = 2'd3
   } fld_e;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
   import seg_xlat_pkg::*;
#(
   parameter int SEG_COUNT = 8,
   parameter int ADDR_W    = 32,
   localparam int SEG_W    = $clog2(SEG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEG_W-1:0]  wseg,
   input  fld_e              wfield,
   input  logic [ADDR_W-1:0] wdata,
   input  logic [SEG_W-1:0]  rseg,
   output logic [ADDR_W-1:0] rbase,
   output logic [ADDR_W-1:0] rlower,
   output logic [ADDR_W-1:0] rupper
);
   logic [ADDR_W-1:0] base_q  [SEG_COUNT];
   logic [ADDR_W-1:0] lower_q [SEG_COUNT];
   logic [ADDR_W-1:0] upper_q [SEG_COUNT];

   for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
      logic hit;
      assign hit = we && (wseg == SEG_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[s]  <= '0;
            lower_q[s] <= '0;
            upper_q[s] <= '0;
         end else if (hit) begin
            case (wfield)
               FLD_BASE:  base_q[s]  <= wdata;
               FLD_LOWER: lower_q[s] <= wdata;
               FLD_UPPER: upper_q[s] <= wdata;
               default:   ;
            endcase
         end
      end
   end

   assign rbase  = base_q[rseg];
   assign rlower = lower_q[rseg];
   assign rupper = upper_q[rseg];
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check #(
   parameter int ADDR_W     = 32,
   parameter bit UPPER_INCL = 1'b0
) (
   input  logic [ADDR_W-1:0] off,
   input  logic [ADDR_W-1:0] lower,
   input  logic [ADDR_W-1:0] upper,
   output logic              in_range
);
   logic above_lo;
   logic below_hi;

   assign above_lo = (off >= lower);

   if (UPPER_INCL) begin : g_hi_incl
      assign below_hi = (off <= upper);
   end else begin : g_hi_excl
      assign below_hi = (off < upper);
   end

   assign in_range = above_lo && below_hi;
endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_ok,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              drain,
   output logic              out_valid,
   output logic              out_err,
   output logic [ADDR_W-1:0] out_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_addr  <= '0;
      end else if (load) begin
         out_valid <= load_ok;
         out_err   <= !load_ok;
         out_addr  <= load_ok ? load_addr : '0;
      end else if (drain) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_addr  <= '0;
      end
   end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
   import seg_xlat_pkg::*;
#(
   parameter int SEG_COUNT  = 8,
   parameter int ADDR_W     = 32,
   parameter bit UPPER_INCL = 1'b0,
   localparam int SEG_W     = $clog2(SEG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEG_W-1:0]  cfg_seg,
   input  logic [1:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_data,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [ADDR_W-1:0] req_off,
   output logic              rsp_valid,
   output logic              rsp_err,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_paddr
);
   if (SEG_COUNT < 2 || (SEG_COUNT & (SEG_COUNT - 1)) != 0) begin : g_bad_count
      $error("seg_xlat: SEG_COUNT must be a power of two of at least 2");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_width
      $error("seg_xlat: ADDR_W must lie between 8 and 64");
   end

   logic [ADDR_W-1:0] d_base;
   logic [ADDR_W-1:0] d_lower;
   logic [ADDR_W-1:0] d_upper;
   logic              ok;
   logic [ADDR_W-1:0] sum;
   logic              slot_full;
   logic              accept;

   seg_desc_table #(
      .SEG_COUNT (SEG_COUNT),
      .ADDR_W    (ADDR_W)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .wseg   (cfg_seg),
      .wfield (fld_e'(cfg_field)),
      .wdata  (cfg_data),
      .rseg   (req_seg),
      .rbase  (d_base),
      .rlower (d_lower),
      .rupper (d_upper)
   );

   seg_bound_check #(
      .ADDR_W     (ADDR_W),
      .UPPER_INCL (UPPER_INCL)
   ) u_bound (
      .off      (req_off),
      .lower    (d_lower),
      .upper    (d_upper),
      .in_range (ok)
   );

   assign sum       = d_base + req_off;
   assign slot_full = rsp_valid || rsp_err;
   assign req_ready = !slot_full || rsp_ready;
   assign accept    = req_valid && req_ready;

   seg_resp_reg #(
      .ADDR_W (ADDR_W)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_ok   (ok),
      .load_addr (sum),
      .drain     (rsp_ready),
      .out_valid (rsp_valid),
      .out_err   (rsp_err),
      .out_addr  (rsp_paddr)
   );
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic              rsp_ready,
   input logic [ADDR_W-1:0] rsp_paddr
);
   AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_paddr == '0)); // R4

   AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && rsp_err)); // R4

   AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_valid || rsp_err)); // R2

   AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(req_valid && req_ready) && rsp_ready) |=> (!rsp_valid && !rsp_err)); // R6

   AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((rsp_valid || rsp_err) && !rsp_ready) |-> !req_ready); // R6

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((rsp_valid || rsp_err) && !rsp_ready) |=>
         ($stable(rsp_valid) && $stable(rsp_err) && $stable(rsp_paddr))); // R6
endmodule

bind seg_xlat seg_xlat_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_ready (rsp_ready),
   .rsp_paddr (rsp_paddr)
);

// File: tb/tb_seg_xlat.sv
`timescale 1ns/1ps
module tb_seg_xlat;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_seg;
   logic [1:0]  cfg_field;
   logic [31:0] cfg_data;
   logic        req_valid;
   logic        req_ready;
   logic [2:0]  req_seg;
   logic [31:0] req_off;
   logic        rsp_valid;
   logic        rsp_err;
   logic        rsp_ready;
   logic [31:0] rsp_paddr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   seg_xlat dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_field(cfg_field), .cfg_data(cfg_data),
      .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr)
   );

   typedef struct packed {
      logic [2:0]  seg;
      logic [31:0] off;
      logic [31:0] paddr;
      logic        err;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 32'h0000_0100, 32'h1000_0100, 1'b0},  // R3 lower edge passes
      '{3'd0, 32'h0000_01FF, 32'h1000_01FF, 1'b0},  // R2
      '{3'd0, 32'h0000_0200, 32'h0000_0000, 1'b1},  // R3 upper edge fails
      '{3'd0, 32'h0000_00FF, 32'h0000_0000, 1'b1},  // R3 below lower fails
      '{3'd1, 32'h0000_0000, 32'h8000_0000, 1'b0},  // R8
      '{3'd1, 32'h0000_0ABC, 32'h8000_0ABC, 1'b0},  // R2
      '{3'd2, 32'h0000_0180, 32'h0000_0080, 1'b0},  // R2 carry dropped
      '{3'd3, 32'h0000_0000, 32'h0000_0000, 1'b1}   // R8 untouched segment
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] s, input logic [1:0] f, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_seg = s; cfg_field = f; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic xact(input string req, input logic [2:0] s, input logic [31:0] off,
                       input logic [31:0] exp_addr, input logic exp_err);
      @(negedge clk);
      req_valid = 1'b1; req_seg = s; req_off = off;
      @(negedge clk);
      req_valid = 1'b0;
      check(req, {rsp_err, rsp_valid}, {exp_err, !exp_err});
      check(req, rsp_paddr, exp_addr);
   endtask

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_seg = '0; cfg_field = '0; cfg_data = '0;
      req_valid = 1'b0; req_seg = '0; req_off = '0; rsp_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle outputs", {rsp_valid, rsp_err, req_ready}, 3'b001);
      xact("R1 unconfigured faults", 3'd0, 32'h0, 32'h0, 1'b1);

      cfg_write(3'd0, 2'd0, 32'h1000_0000);
      cfg_write(3'd0, 2'd1, 32'h0000_0100);
      cfg_write(3'd0, 2'd2, 32'h0000_0200);
      cfg_write(3'd1, 2'd0, 32'h8000_0000);
      cfg_write(3'd1, 2'd2, 32'h0000_1000);
      cfg_write(3'd2, 2'd0, 32'hFFFF_FF00);
      cfg_write(3'd2, 2'd2, 32'h0000_0400);

      for (int i = 0; i < NV; i++) begin
         xact($sformatf("R3/R4 vector %0d", i), VEC[i].seg, VEC[i].off, VEC[i].paddr, VEC[i].err);
      end

      // R5: a write and a request at the same edge; the request sees the old base
      @(negedge clk);
      cfg_we = 1'b1; cfg_seg = 3'd0; cfg_field = 2'd0; cfg_data = 32'h2000_0000;
      req_valid = 1'b1; req_seg = 3'd0; req_off = 32'h150;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      check("R5 same-edge write uses old base", rsp_paddr, 32'h1000_0150);
      // R7: after relocation the new base applies and the bounds still hold
      xact("R7 relocated base", 3'd0, 32'h150, 32'h2000_0150, 1'b0);
      xact("R7 bounds kept after relocation", 3'd0, 32'h200, 32'h0, 1'b1);
      // R7: field code 3 writes nothing
      cfg_write(3'd1, 2'd3, 32'h0000_0000);
      xact("R7 field code 3 ignored", 3'd1, 32'hABC, 32'h8000_0ABC, 1'b0);
      xact("R8 other segment unchanged", 3'd2, 32'h10, 32'hFFFF_FF10, 1'b0);

      // R6: backpressure holds the response and blocks new requests
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b1; req_seg = 3'd1; req_off = 32'h4;
      @(negedge clk);
      req_off = 32'h8;
      check("R6 first response", rsp_paddr, 32'h8000_0004);
      check("R6 ready low while held", {req_ready, rsp_valid}, 2'b01);
      @(negedge clk);
      check("R6 response held", rsp_paddr, 32'h8000_0004);
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R6 next accepted on drain edge", {rsp_valid, rsp_paddr}, {1'b1, 32'h8000_0008});
      @(negedge clk);
      check("R6 slot empties", {rsp_valid, rsp_err}, 2'b00);

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule